// File: doc/BRIEF.md
# Fractionally Adjustable Time Counter

A free-running time-of-day counter that counts nanoseconds in a 40-bit register. Each clock cycle is one tick. On every tick the count moves forward by a fixed step of 8 ns. A 32-bit sub-nanosecond residue register sits below the count and accumulates a signed correction taken from a programmable increment register. When the residue overflows, the step is lengthened by 1 ns. When it underflows, the step is shortened by 1 ns. Software trims the rate of the clock through this register.

Software reaches the block through a 32-bit register port. The time is split across three words: the residue, the low 32 bits of the count and the upper 8 bits of the count. Reading the residue word captures all three words at once, so that the two later word reads form one coherent value. A two-word write sets the time. A control word freezes or releases the counter.

Top module: `frac_time_counter`

## Requirements
- R1: After reset the count, the residue and the increment register are zero, and the control word reads 0x8000_0000, which means the counter is stopped.
- R2: While running with an increment of zero, the count rises by exactly 8 on each clock cycle and the residue stays at zero.
- R3: When increment bit 31 is 0, the residue adds bits 30:0 on each tick. A carry out of bit 31 of the residue makes that tick's step 9 ns.
- R4: When increment bit 31 is 1, the residue subtracts bits 30:0 on each tick. A borrow makes that tick's step 7 ns.
- R5: The count wraps modulo 2^40 with no saturation. A read of the high word returns the count bits 39:32 in bits 7:0 and zero in bits 31:8.
- R6: A read of the residue word (address 0) returns the live residue and captures residue, low and high words. While the capture is held, reads of the low word (address 1) and high word (address 2) return the captured values. A high-word read releases the capture. A further residue read while the capture is held replaces it.
- R7: With no capture held, reads of the low and high words return the live count.
- R8: A write to the low word is staged. A write to the high word loads the count with {write data bits 7:0, staged low word} and clears the residue. A write to the residue word has no effect.
- R9: Control bit 31 at 1 freezes the count and the residue. Writing 0 to the control word (address 4) lets both advance from the next cycle on.
- R10: The increment register is at address 3. Read data appears one cycle after the read strobe and holds between reads. A read of any other address returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one counter tick per cycle |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 3 | Register word address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Registered read data |

## Verification
A wrong residue does not show at once. It shows as a step of 7 or 9 ns appearing on the wrong tick, so the count drifts by 1 ns within a few ticks of a strong correction. A residue read also exposes the residue directly in the next cycle. A broken capture shows up as a low or high word that does not match the residue read that went before it. A wrong wrap or a wrong width only shows at the 2^40 boundary, so the bench loads a time just below that boundary and checks it there. Every read is compared with a behavioural model in the cycle after its strobe.

// File: rtl/ftc_pkg.sv
package ftc_pkg;
  localparam int ADDR_W = 3;
  typedef logic [ADDR_W-1:0] ftc_addr_t;
  localparam ftc_addr_t A_RESID  = 3'd0;
  localparam ftc_addr_t A_NS_LO  = 3'd1;
  localparam ftc_addr_t A_NS_HI  = 3'd2;
  localparam ftc_addr_t A_INCR   = 3'd3;
  localparam ftc_addr_t A_CTRL   = 3'd4;
endpackage

// File: rtl/ftc_frac_step.sv
module ftc_frac_step #(
  parameter int FRAC_W  = 32,
  parameter int NS_W    = 40,
  parameter int STEP_NS = 8
) (
  input  logic [FRAC_W-1:0] frac_q,
  input  logic [FRAC_W-1:0] incr,
  output logic [FRAC_W-1:0] frac_d,
  output logic [NS_W-1:0]   ns_step
);
  logic [FRAC_W:0] mag, sum, diff;
  logic            neg;

  always_comb begin
    neg  = incr[FRAC_W-1];
    mag  = {2'b00, incr[FRAC_W-2:0]};
    sum  = {1'b0, frac_q} + mag;
    diff = {1'b0, frac_q} - mag;
    if (neg) begin
      frac_d  = diff[FRAC_W-1:0];
      ns_step = NS_W'(STEP_NS) - NS_W'(diff[FRAC_W]);
    end else begin
      frac_d  = sum[FRAC_W-1:0];
      ns_step = NS_W'(STEP_NS) + NS_W'(sum[FRAC_W]);
    end
  end
endmodule

// File: rtl/ftc_time_core.sv
module ftc_time_core #(
  parameter int FRAC_W  = 32,
  parameter int NS_W    = 40,
  parameter int STEP_NS = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              run,
  input  logic [FRAC_W-1:0] incr,
  input  logic              set_en,
  input  logic [NS_W-1:0]   set_ns,
  output logic [NS_W-1:0]   ns_q,
  output logic [FRAC_W-1:0] frac_q
);
  logic [FRAC_W-1:0] frac_d;
  logic [NS_W-1:0]   ns_step;

  ftc_frac_step #(.FRAC_W(FRAC_W), .NS_W(NS_W), .STEP_NS(STEP_NS)) step_i (
    .frac_q(frac_q), .incr(incr), .frac_d(frac_d), .ns_step(ns_step)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ns_q   <= '0;
      frac_q <= '0;
    end else if (set_en) begin
      ns_q   <= set_ns;
      frac_q <= '0;
    end else if (run) begin
      ns_q   <= ns_q + ns_step;
      frac_q <= frac_d;
    end
  end

  // R2 R3 R4 R5
  step_range_chk: assert property (@(posedge clk) disable iff (rst)
    (run && !set_en) |=> ((ns_q - $past(ns_q)) == NS_W'(STEP_NS)) ||
                         ((ns_q - $past(ns_q)) == NS_W'(STEP_NS + 1)) ||
                         ((ns_q - $past(ns_q)) == NS_W'(STEP_NS - 1)));
  // R9
  frozen_chk: assert property (@(posedge clk) disable iff (rst)
    (!run && !set_en) |=> ($stable(ns_q) && $stable(frac_q)));
  // R8
  set_load_chk: assert property (@(posedge clk) disable iff (rst)
    set_en |=> (ns_q == $past(set_ns) && frac_q == '0));
endmodule

// File: rtl/ftc_snapshot.sv
module ftc_snapshot #(
  parameter int FRAC_W = 32,
  parameter int NS_W   = 40
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cap,
  input  logic              rel,
  input  logic [FRAC_W-1:0] live_frac,
  input  logic [NS_W-1:0]   live_ns,
  output logic              held,
  output logic [FRAC_W-1:0] snap_frac,
  output logic [NS_W-1:0]   snap_ns
);
  always_ff @(posedge clk) begin
    if (rst) begin
      held      <= 1'b0;
      snap_frac <= '0;
      snap_ns   <= '0;
    end else if (cap) begin
      held      <= 1'b1;
      snap_frac <= live_frac;
      snap_ns   <= live_ns;
    end else if (rel) begin
      held      <= 1'b0;
    end
  end

  // R6
  snap_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (held && !cap) |=> $stable(snap_ns));
  // R6
  snap_release_chk: assert property (@(posedge clk) disable iff (rst)
    (rel && !cap) |=> !held);
endmodule

// File: rtl/frac_time_counter.sv
module frac_time_counter #(
  parameter int DATA_W  = 32,
  parameter int NS_W    = 40,
  parameter int STEP_NS = 8
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     reg_wr,
  input  logic                     reg_rd,
  input  logic [ftc_pkg::ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0]        reg_wdata,
  output logic [DATA_W-1:0]        reg_rdata
);
  import ftc_pkg::*;
  localparam int HI_W = NS_W - DATA_W;

  logic [DATA_W-1:0] incr_q, ctrl_q, stage_lo_q;
  logic [NS_W-1:0]   ns_q, snap_ns;
  logic [DATA_W-1:0] frac_q, snap_frac;
  logic              held, set_en, run, cap, rel;

  assign run    = !ctrl_q[DATA_W-1];
  assign set_en = reg_wr && (reg_addr == A_NS_HI);
  assign cap    = reg_rd && (reg_addr == A_RESID);
  assign rel    = reg_rd && (reg_addr == A_NS_HI);

  always_ff @(posedge clk) begin
    if (rst) begin
      incr_q     <= '0;
      ctrl_q     <= {1'b1, {(DATA_W-1){1'b0}}};
      stage_lo_q <= '0;
    end else if (reg_wr) begin
      case (reg_addr)
        A_NS_LO: stage_lo_q <= reg_wdata;
        A_INCR:  incr_q     <= reg_wdata;
        A_CTRL:  ctrl_q     <= reg_wdata;
        default: ;
      endcase
    end
  end

  ftc_time_core #(.FRAC_W(DATA_W), .NS_W(NS_W), .STEP_NS(STEP_NS)) core_i (
    .clk(clk), .rst(rst), .run(run), .incr(incr_q), .set_en(set_en),
    .set_ns({reg_wdata[HI_W-1:0], stage_lo_q}), .ns_q(ns_q), .frac_q(frac_q)
  );

  ftc_snapshot #(.FRAC_W(DATA_W), .NS_W(NS_W)) snap_i (
    .clk(clk), .rst(rst), .cap(cap), .rel(rel), .live_frac(frac_q),
    .live_ns(ns_q), .held(held), .snap_frac(snap_frac), .snap_ns(snap_ns)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata <= '0;
    end else if (reg_rd) begin
      case (reg_addr)
        A_RESID: reg_rdata <= frac_q;
        A_NS_LO: reg_rdata <= held ? snap_ns[DATA_W-1:0] : ns_q[DATA_W-1:0];
        A_NS_HI: reg_rdata <= DATA_W'(held ? snap_ns[NS_W-1:DATA_W]
                                           : ns_q[NS_W-1:DATA_W]);
        A_INCR:  reg_rdata <= incr_q;
        A_CTRL:  reg_rdata <= ctrl_q;
        default: reg_rdata <= '0;
      endcase
    end
  end

  // R5
  hi_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (reg_rd && reg_addr == A_NS_HI) |=> (reg_rdata[DATA_W-1:HI_W] == '0));
  // R10
  rdata_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !reg_rd |=> $stable(reg_rdata));
  // R6
  resid_read_chk: assert property (@(posedge clk) disable iff (rst)
    cap |=> (reg_rdata == snap_frac));
endmodule

// File: tb/frac_time_counter_tb_top.sv
module frac_time_counter_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;

  int n_chk = 0, n_fail = 0, cyc = 0;
  string tag = "R1";

  longint m_ns = 0, m_frac = 0, m_incr = 0, m_ctrl = 64'h8000_0000, m_stage = 0;
  longint s_ns = 0, s_frac = 0, m_rdata = 0;
  bit     m_held = 0;
  localparam longint M32 = 64'hFFFF_FFFF;
  localparam longint M40 = 64'hFF_FFFF_FFFF;

  frac_time_counter dut_i (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
  );

  always #5 clk = ~clk;

  // Behavioural reference, updated at each rising edge from pre-edge state.
  always @(posedge clk) begin
    if (rst) begin
      m_ns = 0; m_frac = 0; m_incr = 0; m_ctrl = 64'h8000_0000; m_stage = 0;
      m_held = 0; m_rdata = 0;
    end else begin
      longint nns, nfr, mag, t;
      bit doset;
      nns = m_ns; nfr = m_frac; doset = 0;
      if (reg_rd) begin
        case (reg_addr)
          3'd0: begin m_rdata = m_frac; s_ns = m_ns; s_frac = m_frac; m_held = 1; end
          3'd1: m_rdata = (m_held ? s_ns : m_ns) & M32;
          3'd2: begin m_rdata = (m_held ? s_ns : m_ns) >> 32; m_held = 0; end
          3'd3: m_rdata = m_incr;
          3'd4: m_rdata = m_ctrl;
          default: m_rdata = 0;
        endcase
      end
      if (m_ctrl[31] == 1'b0) begin
        mag = m_incr & 64'h7FFF_FFFF;
        if (m_incr[31]) begin
          t = m_frac - mag;
          nns = m_ns + ((t < 0) ? 7 : 8);
          nfr = (t < 0) ? t + 64'h1_0000_0000 : t;
        end else begin
          t = m_frac + mag;
          nns = m_ns + ((t > M32) ? 9 : 8);
          nfr = t & M32;
        end
      end
      if (reg_wr) begin
        case (reg_addr)
          3'd1: m_stage = reg_wdata;
          3'd2: begin doset = 1; nns = ((longint'(reg_wdata) & 64'hFF) << 32) | m_stage; nfr = 0; end
          3'd3: m_incr = reg_wdata;
          3'd4: m_ctrl = reg_wdata;
          default: ;
        endcase
      end
      m_ns = nns & M40; m_frac = nfr;
      if (doset) m_frac = 0;
    end
  end

  always @(negedge clk) begin
    if (!rst) begin
      n_chk++;
      if (longint'(reg_rdata) != m_rdata) begin
        n_fail++;
        $display("FAIL %s model compare: rdata actual %h expected %h", tag, reg_rdata, m_rdata[31:0]);
      end
    end
  end

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s directed: actual %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    reg_rd = 1; reg_addr = a;
    @(negedge clk);
    reg_rd = 0;
    d = reg_rdata;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic finish_run;
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      n_fail++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
      finish_run();
    end
  end

  initial begin
    logic [31:0] v;
    repeat (4) @(negedge clk);
    rst = 0;
    tag = "R1";
    rd(3'd4, v); chk("R1", v, 32'h8000_0000);
    rd(3'd3, v); chk("R1", v, 32'h0);
    rd(3'd0, v); chk("R1", v, 32'h0);
    rd(3'd2, v); chk("R1", v, 32'h0);
    tag = "R9"; idle(5);
    rd(3'd1, v); chk("R9", v, 32'h0);
    tag = "R2"; wr(3'd4, 32'h0); idle(6);
    rd(3'd0, v); chk("R2", v, 32'h0);
    tag = "R6"; idle(3); rd(3'd1, v); rd(3'd2, v);
    tag = "R7"; rd(3'd1, v); idle(2); rd(3'd1, v); rd(3'd2, v);
    tag = "R3"; wr(3'd3, 32'h4000_0000);
    for (int i = 0; i < 6; i++) begin rd(3'd0, v); rd(3'd1, v); rd(3'd2, v); end
    wr(3'd3, 32'h7FFF_FFFF);
    for (int i = 0; i < 4; i++) begin rd(3'd0, v); rd(3'd1, v); end
    tag = "R4"; wr(3'd3, 32'hC000_0000);
    for (int i = 0; i < 6; i++) begin rd(3'd0, v); rd(3'd1, v); rd(3'd2, v); end
    wr(3'd3, 32'hFFFF_FFFF);
    for (int i = 0; i < 4; i++) begin rd(3'd0, v); rd(3'd1, v); end
    tag = "R8"; wr(3'd0, 32'h1234_5678); rd(3'd0, v);
    wr(3'd4, 32'h8000_0000); wr(3'd3, 32'h0);
    wr(3'd1, 32'hFFFF_FFF8); wr(3'd2, 32'hABCD_EFFF);
    rd(3'd0, v); chk("R8", v, 32'h0);
    rd(3'd1, v); chk("R8", v, 32'hFFFF_FFF8);
    rd(3'd2, v); chk("R5", v, 32'h0000_00FF);
    tag = "R5"; wr(3'd4, 32'h0); idle(1); wr(3'd4, 32'h8000_0000);
    rd(3'd1, v); chk("R5", v, 32'h0000_0008);
    rd(3'd2, v); chk("R5", v, 32'h0);
    tag = "R6"; wr(3'd3, 32'h2000_0001); wr(3'd4, 32'h0);
    rd(3'd0, v); idle(3); rd(3'd0, v); idle(3); rd(3'd1, v); idle(2); rd(3'd2, v);
    rd(3'd1, v);
    tag = "R10"; rd(3'd7, v); chk("R10", v, 32'h0);
    idle(3); chk("R10", reg_rdata, 32'h0);
    rd(3'd3, v); chk("R10", v, 32'h2000_0001);
    idle(2);
    finish_run();
  end
endmodule